// File: doc/BRIEF.md
# Stepped Shutdown Countdown Timer

This block is an off timer for a small appliance controller. One debounced button sets a shutdown delay in fixed steps of thirty minutes. Each accepted press adds a step, and after nine steps the next press clears the timer. When the delay is nonzero, the block counts the remaining time down in real time from a slow clock-enable tick. It shows the remaining time as a whole number of steps. When the count runs out it raises a shutdown request, and its status indicator changes from steady to blinking.

The tick is a clock enable, normally at 4 Hz, so one minute is `TICKS_PER_MIN` ticks. That count, the step length, the step limit and the blink half-period are all parameters. Debouncing and display decoding are done outside the block.

Top module: `stepped_off_timer`

## Requirements
- R1: After reset the shown step count is 0, the shutdown level and shutdown pulse are low, and the status indicator is lit.
- R2: A press while not expired raises the preset by one step and restarts the countdown from it. On the clock after the press the shown count equals the new preset.
- R3: The preset never exceeds nine steps (270 minutes). A press at nine steps sets the preset to zero, which means the timer is off: the shown count is 0, there is no shutdown, and the indicator stays steady.
- R4: Remaining minutes drop by one only after `TICKS_PER_MIN` ticks. Cycles without a tick do not advance time, so a full step takes exactly 30 minutes of ticks.
- R5: The shown count is the remaining minutes divided by 30 and rounded up. Nonzero remaining time never shows as 0.
- R6: A press during a countdown restarts the count from the new preset and clears the partial minute. A press wins over a tick in the same cycle.
- R7: On the tick that completes the last minute, the shutdown level rises and holds until reset. The shutdown pulse is high for exactly that first cycle, and the shown count is 0.
- R8: The indicator is lit steadily until expiry. It goes dark on the expiry cycle and then toggles every `BLINK_TICKS` ticks (2 by default, a 1 Hz blink at 4 Hz).
- R9: Presses after expiry are ignored: the shown count stays 0 and shutdown stays high.
- R10: With the timer off (preset zero), ticks change nothing at the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Time-base clock enable (one per quarter second nominally) |
| press_i | input | 1 | Debounced button, one-cycle pulse per press |
| steps_shown_o | output | $clog2(MAX_STEPS+1) | Remaining time in steps, rounded up |
| shutdown_o | output | 1 | Shutdown request level, held until reset |
| shutdown_pulse_o | output | 1 | One-cycle pulse when shutdown starts |
| status_led_o | output | 1 | Status indicator: steady on, blinking after expiry |

## Verification
The bench builds the block with `TICKS_PER_MIN` = 2 and leaves the other parameters at their defaults. A thirty-minute step then takes 60 ticks, and the nine-step limit takes 540. This short minute puts full countdowns, the exact expiry tick, the rounded-up display at step boundaries and several blink periods within a few thousand cycles. The step arithmetic and the nine-step wrap are unchanged from the real configuration.

// File: rtl/sot_pkg.sv
package sot_pkg;

  // Preset increment with wrap to zero (timer off) beyond the limit.
  function automatic int unsigned wrap_inc(input int unsigned cur, input int unsigned lim);
    return (cur >= lim) ? 0 : cur + 1;
  endfunction

  // Whole steps needed to cover a remaining time, rounded up.
  function automatic int unsigned ceil_steps(input int unsigned minutes, input int unsigned step_len);
    return (minutes + step_len - 1) / step_len;
  endfunction

  // Counter width for a modulus of at least 2.
  function automatic int unsigned cnt_width(input int unsigned modulus);
    return (modulus > 1) ? $clog2(modulus) : 1;
  endfunction

endpackage

// File: rtl/sot_preset.sv
module sot_preset #(
  parameter int unsigned MAX_STEPS = 9,
  localparam int unsigned SW = $clog2(MAX_STEPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          press_i,
  input  logic          lock_i,
  output logic          load_o,
  output logic [SW-1:0] steps_nxt_o
);
  logic [SW-1:0] steps_q;

  assign load_o      = press_i && !lock_i;
  assign steps_nxt_o = SW'(sot_pkg::wrap_inc(32'(steps_q), MAX_STEPS));

  always_ff @(posedge clk) begin
    if (!rst_n)      steps_q <= '0;
    else if (load_o) steps_q <= steps_nxt_o;
  end
endmodule

// File: rtl/sot_minute_base.sv
module sot_minute_base #(
  parameter int unsigned TICKS_PER_MIN = 240,
  localparam int unsigned CW = sot_pkg::cnt_width(TICKS_PER_MIN)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic clear_i,
  input  logic run_i,
  output logic min_stb_o
);
  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end    = (cnt_q == CW'(TICKS_PER_MIN - 1));
  assign min_stb_o = tick_i && run_i && !clear_i && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i || !run_i) cnt_q <= '0;
    else if (tick_i)                 cnt_q <= at_end ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/sot_countdown.sv
module sot_countdown #(
  parameter int unsigned MAX_STEPS = 9,
  parameter int unsigned STEP_MIN  = 30,
  localparam int unsigned SW = $clog2(MAX_STEPS + 1),
  localparam int unsigned MW = $clog2(MAX_STEPS * STEP_MIN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [SW-1:0] load_steps_i,
  input  logic          min_stb_i,
  output logic          run_o,
  output logic          expire_o,
  output logic          done_o,
  output logic          pulse_o,
  output logic [SW-1:0] shown_o
);
  logic [MW-1:0] rem_q;

  assign run_o    = (rem_q != '0) && !done_o;
  assign expire_o = min_stb_i && (rem_q == MW'(1));
  assign shown_o  = SW'(sot_pkg::ceil_steps(32'(rem_q), STEP_MIN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q   <= '0;
      done_o  <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= expire_o;
      if (expire_o) done_o <= 1'b1;
      if (load_i)         rem_q <= MW'(32'(load_steps_i) * STEP_MIN);
      else if (min_stb_i) rem_q <= rem_q - 1'b1;
    end
  end
endmodule

// File: rtl/sot_blink.sv
module sot_blink #(
  parameter int unsigned BLINK_TICKS = 2,
  localparam int unsigned BW = sot_pkg::cnt_width(BLINK_TICKS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic expire_i,
  input  logic done_i,
  output logic led_o
);
  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      led_o <= 1'b1;
      cnt_q <= '0;
    end else if (expire_i) begin
      led_o <= 1'b0;
      cnt_q <= '0;
    end else if (done_i && tick_i) begin
      if (cnt_q == BW'(BLINK_TICKS - 1)) begin
        cnt_q <= '0;
        led_o <= !led_o;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/stepped_off_timer.sv
module stepped_off_timer #(
  parameter int unsigned TICKS_PER_MIN = 240,
  parameter int unsigned STEP_MIN      = 30,
  parameter int unsigned MAX_STEPS     = 9,
  parameter int unsigned BLINK_TICKS   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic press_i,
  output logic [$clog2(MAX_STEPS+1)-1:0] steps_shown_o,
  output logic shutdown_o,
  output logic shutdown_pulse_o,
  output logic status_led_o
);
  localparam int unsigned SW = $clog2(MAX_STEPS + 1);

  // Named internal events, also observed by the checker.
  logic          load_w;
  logic [SW-1:0] load_steps_w;
  logic          min_stb_w;
  logic          expire_w;
  logic          run_w;

  sot_preset #(.MAX_STEPS(MAX_STEPS)) u_preset (
    .clk(clk), .rst_n(rst_n), .press_i(press_i), .lock_i(shutdown_o),
    .load_o(load_w), .steps_nxt_o(load_steps_w)
  );

  sot_minute_base #(.TICKS_PER_MIN(TICKS_PER_MIN)) u_base (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .clear_i(load_w),
    .run_i(run_w), .min_stb_o(min_stb_w)
  );

  sot_countdown #(.MAX_STEPS(MAX_STEPS), .STEP_MIN(STEP_MIN)) u_count (
    .clk(clk), .rst_n(rst_n), .load_i(load_w), .load_steps_i(load_steps_w),
    .min_stb_i(min_stb_w), .run_o(run_w), .expire_o(expire_w),
    .done_o(shutdown_o), .pulse_o(shutdown_pulse_o), .shown_o(steps_shown_o)
  );

  sot_blink #(.BLINK_TICKS(BLINK_TICKS)) u_blink (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .expire_i(expire_w),
    .done_i(shutdown_o), .led_o(status_led_o)
  );
endmodule

// File: rtl/sot_checker.sv
module sot_checker #(
  parameter int unsigned MAX_STEPS = 9,
  localparam int unsigned SW = $clog2(MAX_STEPS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_i,
  input logic          press_i,
  input logic [SW-1:0] steps_shown_o,
  input logic          shutdown_o,
  input logic          shutdown_pulse_o,
  input logic          status_led_o,
  input logic          load_w,
  input logic [SW-1:0] load_steps_w,
  input logic          expire_w
);
  // R3
  steps_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    steps_shown_o <= SW'(MAX_STEPS));
  // R2
  load_shows_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_w |=> steps_shown_o == $past(load_steps_w));
  // R7
  pulse_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_pulse_o |-> $rose(shutdown_o));
  // R7
  shutdown_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_o |=> shutdown_o);
  // R7
  expire_to_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_w |=> shutdown_pulse_o);
  // R8
  led_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shutdown_o |-> status_led_o);
  // R9
  done_shows_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_o |-> steps_shown_o == '0);
  // R4
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !press_i) |=> $stable(steps_shown_o) && $stable(status_led_o));
endmodule

bind stepped_off_timer sot_checker #(.MAX_STEPS(MAX_STEPS)) u_sot_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .press_i(press_i),
  .steps_shown_o(steps_shown_o), .shutdown_o(shutdown_o),
  .shutdown_pulse_o(shutdown_pulse_o), .status_led_o(status_led_o),
  .load_w(load_w), .load_steps_w(load_steps_w), .expire_w(expire_w)
);

// File: tb/stepped_off_timer_bench.sv
`timescale 1ns/1ps
module stepped_off_timer_bench;
  localparam int TPM = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0;
  logic press_i = 1'b0;
  logic [3:0] steps_shown_o;
  logic shutdown_o, shutdown_pulse_o, status_led_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  stepped_off_timer #(.TICKS_PER_MIN(TPM)) u_stepped_off_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .press_i(press_i),
    .steps_shown_o(steps_shown_o), .shutdown_o(shutdown_o),
    .shutdown_pulse_o(shutdown_pulse_o), .status_led_o(status_led_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 100000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=%0d expected below=%0d cycles", cycles, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // Drive at a falling edge; return at the next falling edge, after one rising edge.
  task automatic cyc(input logic p, input logic t);
    press_i = p;
    tick_i  = t;
    @(negedge clk);
    press_i = 1'b0;
    tick_i  = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Vector: [15] press, [14:5] ticks after it, [4:1] expected steps, [0] expected shutdown.
  localparam logic [15:0] VEC [8] = '{
    {1'b1, 10'd0,   4'd1, 1'b0},  // R2 first press
    {1'b1, 10'd0,   4'd2, 1'b0},  // R2 second press
    {1'b0, 10'd1,   4'd2, 1'b0},  // R4 partial minute
    {1'b0, 10'd1,   4'd2, 1'b0},  // R5 59 min shows 2
    {1'b0, 10'd58,  4'd1, 1'b0},  // R5 30 min shows 1
    {1'b0, 10'd1,   4'd1, 1'b0},  // R5 just under 30 min
    {1'b1, 10'd0,   4'd3, 1'b0},  // R6 restart from preset 3
    {1'b0, 10'd119, 4'd2, 1'b0}   // R4 31 min left shows 2
  };

  initial begin
    @(negedge clk);
    do_reset();
    // R1
    chk("R1 steps", int'(steps_shown_o), 0);
    chk("R1 shutdown", int'(shutdown_o), 0);
    chk("R1 pulse", int'(shutdown_pulse_o), 0);
    chk("R1 led", int'(status_led_o), 1);

    for (int v = 0; v < 8; v++) begin
      if (VEC[v][15]) cyc(1'b1, 1'b0);
      ticks(int'(VEC[v][14:5]));
      chk("R2/R4/R5/R6 vector steps", int'(steps_shown_o), int'(VEC[v][4:1]));
      chk("R7 vector shutdown", int'(shutdown_o), int'(VEC[v][0]));
    end

    // R6 press and tick in the same cycle: press wins
    cyc(1'b1, 1'b1);
    chk("R6 press over tick", int'(steps_shown_o), 4);
    // R4 idle cycles hold the count
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0);
    chk("R4 no tick hold", int'(steps_shown_o), 4);
    chk("R8 steady while running", int'(status_led_o), 1);

    // R3 wrap
    do_reset();
    for (int i = 0; i < 9; i++) cyc(1'b1, 1'b0);
    chk("R3 max nine", int'(steps_shown_o), 9);
    cyc(1'b1, 1'b0);
    chk("R3 wrap to zero", int'(steps_shown_o), 0);
    ticks(10);
    chk("R10 idle steps", int'(steps_shown_o), 0);
    chk("R10 idle shutdown", int'(shutdown_o), 0);
    chk("R3 idle led", int'(status_led_o), 1);

    // R7 expiry timing
    do_reset();
    cyc(1'b1, 1'b0);
    ticks(30 * TPM - 1);
    chk("R7 before last tick steps", int'(steps_shown_o), 1);
    chk("R7 before last tick shutdown", int'(shutdown_o), 0);
    ticks(1);
    chk("R7 shutdown rises", int'(shutdown_o), 1);
    chk("R7 pulse", int'(shutdown_pulse_o), 1);
    chk("R7 steps zero", int'(steps_shown_o), 0);
    chk("R8 led dark at expiry", int'(status_led_o), 0);
    cyc(1'b0, 1'b0);
    chk("R7 pulse one cycle", int'(shutdown_pulse_o), 0);
    chk("R7 level held", int'(shutdown_o), 1);
    ticks(1);
    chk("R8 led after one tick", int'(status_led_o), 0);
    ticks(1);
    chk("R8 led toggles on", int'(status_led_o), 1);
    ticks(2);
    chk("R8 led toggles off", int'(status_led_o), 0);
    // R9
    cyc(1'b1, 1'b0);
    chk("R9 press ignored steps", int'(steps_shown_o), 0);
    chk("R9 press ignored shutdown", int'(shutdown_o), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule